// File: doc/BRIEF.md
# Pixel Input Capture with Half-Width Double-Edge Mode

This block receives pixels from a parallel video input port clocked by the source's pixel clock. It delivers one 24-bit RGB pixel per pixel clock into the core clock domain, together with a one-cycle valid strobe and the horizontal and vertical sync levels that belong to that pixel. The port works in one of two widths. In the full-width mode all 24 data lanes are sampled on the rising pixel-clock edge. In the half-width mode only the lower 12 lanes are used, and each pixel is carried in two halves: the low half on the rising edge and the high half on the falling edge. The two halves are joined into one word with the low half in bits 11:0.

An 8-bit mode register, written from the core side, selects the width and holds the colour-space, CCIR656 and embedded-sync options. Those options are stored and read back only. A clock monitor counts pixel-clock rising edges over a fixed window of core cycles. It raises a low flag or a high flag when the count falls outside the range allowed for the current width. The half-width mode has a lower upper limit.

The core clock must run at least three times faster than the pixel clock. The mode register should be changed only while the pixel clock is idle.

Top module: `vcap_top`

## Requirements
- R1: After reset, pix_o, pix_valid_o, hsync_o, vsync_o, clk_low_o, clk_high_o and cfg_rdata_o are all 0.
- R2: A write of cfg_wdata_i stores the fields at bits 7:6 (colour space: 0 RGB, 1 YUV 4:2:2, 2 YUV 4:4:4, 3 stored unchanged), bit 4 (CCIR656), bit 3 (embedded sync) and bit 2 (half-width enable). cfg_rdata_o shows them from the next cycle, bits 5, 1 and 0 read as 0, and the value holds until the next write.
- R3: With bit 2 clear, each pixel is pix_d_i[23:0] as sampled on the rising pclk_i edge; the value present on the falling edge has no effect.
- R4: With bit 2 set, each pixel is {pix_d_i[11:0] at the falling edge, pix_d_i[11:0] at the preceding rising edge}, so the first half lands in bits 11:0.
- R5: With bit 2 set, pix_d_i[23:12] has no effect on pix_o.
- R6: hsync_o and vsync_o carry hsync_i and vsync_i as sampled on the rising edge that starts the same pixel, and they are presented together with that pixel.
- R7: Every pclk_i cycle produces exactly one single-cycle pix_valid_o pulse, in pixel order. pix_o, hsync_o and vsync_o change only in a cycle where pix_valid_o is 1.
- R8: clk_low_o is 1 when the pclk_i rising edges counted in the last complete window of WIN_CYC core cycles are fewer than MIN_KHZ*WIN_CYC/REF_KHZ.
- R9: clk_high_o is 1 when that count exceeds MAX_SDR_KHZ*WIN_CYC/REF_KHZ with bit 2 clear, or MAX_DDR_KHZ*WIN_CYC/REF_KHZ with bit 2 set.
- R10: clk_low_o and clk_high_o change only at the first cycle of a window, which is core cycle k*WIN_CYC after reset release, for k = 1, 2, ...
- R11: The colour-space, CCIR656 and embedded-sync fields have no effect on pix_o, hsync_o or vsync_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Mode register write strobe |
| cfg_wdata_i | input | 8 | Mode register write data |
| cfg_rdata_o | output | 8 | Mode register read-back |
| pclk_i | input | 1 | Pixel clock from the video source |
| pix_d_i | input | PIX_W | Parallel pixel data lanes |
| hsync_i | input | 1 | Horizontal sync from the source |
| vsync_i | input | 1 | Vertical sync from the source |
| pix_o | output | PIX_W | Assembled pixel, core domain |
| pix_valid_o | output | 1 | One-cycle strobe per new pixel |
| hsync_o | output | 1 | Horizontal sync aligned with pix_o |
| vsync_o | output | 1 | Vertical sync aligned with pix_o |
| clk_low_o | output | 1 | Pixel clock below range in last window |
| clk_high_o | output | 1 | Pixel clock above range in last window |

## Verification
The assertions check every cycle that mode read-back follows each write and otherwise holds. They also check that the valid strobe never lasts two cycles, that pixel and sync outputs hold steady outside a strobe, and that the range flags move only at window boundaries. The bench alone shows data correctness. It sweeps pixel values through both widths, including all-zero and all-one halves, and checks the half ordering, the lanes that are ignored, the sync sampling edge and the one-strobe-per-pixel count. It also runs the pixel clock at several rates, below, inside and above the range in each width, to show the flag thresholds and the lower limit of the half-width mode.

// File: rtl/vcap_pkg.sv
`timescale 1ns/1ps
package vcap_pkg;

  typedef enum logic [1:0] {
    CS_RGB    = 2'd0,
    CS_YUV422 = 2'd1,
    CS_YUV444 = 2'd2,
    CS_RSVD   = 2'd3
  } cspace_e;

  typedef struct packed {
    cspace_e cspace;
    logic    ccir;
    logic    embsync;
    logic    ddr;
  } mode_t;

  localparam logic [7:0] MODE_MASK = 8'hDC;

  function automatic mode_t mode_unpack(input logic [7:0] b);
    mode_t m;
    m.cspace  = cspace_e'(b[7:6]);
    m.ccir    = b[4];
    m.embsync = b[3];
    m.ddr     = b[2];
    return m;
  endfunction

  function automatic logic [7:0] mode_pack(input mode_t m);
    return {m.cspace, 1'b0, m.ccir, m.embsync, m.ddr, 2'b00};
  endfunction

endpackage

// File: rtl/vcap_mode_reg.sv
`timescale 1ns/1ps
module vcap_mode_reg
  import vcap_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       ddr_o
);

  mode_t mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= '0;
    else if (we_i) mode_q <= mode_unpack(wdata_i);
  end

  assign rdata_o = mode_pack(mode_q);
  assign ddr_o   = mode_q.ddr;

endmodule

// File: rtl/vcap_capture.sv
`timescale 1ns/1ps
// Pixel-clock domain: rising-edge holding register, falling-edge assembly.
module vcap_capture #(
  parameter int PIX_W = 24
) (
  input  logic             pclk_i,
  input  logic             rst_ni,
  input  logic             ddr_i,
  input  logic [PIX_W-1:0] pix_d_i,
  input  logic             hsync_i,
  input  logic             vsync_i,
  output logic [PIX_W-1:0] word_o,
  output logic [1:0]       sync_o,
  output logic             tog_o
);

  localparam int HALF_W = PIX_W / 2;

  logic [PIX_W-1:0] rise_q;
  logic [1:0]       rsync_q;

  always_ff @(posedge pclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q  <= '0;
      rsync_q <= '0;
    end else begin
      rise_q  <= pix_d_i;
      rsync_q <= {hsync_i, vsync_i};
    end
  end

  always_ff @(negedge pclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= '0;
      sync_o <= '0;
      tog_o  <= 1'b0;
    end else begin
      // half-width: first half is the low half
      word_o <= ddr_i ? {pix_d_i[HALF_W-1:0], rise_q[HALF_W-1:0]} : rise_q;
      sync_o <= rsync_q;
      tog_o  <= ~tog_o;
    end
  end

endmodule

// File: rtl/vcap_handoff.sv
`timescale 1ns/1ps
// Toggle-based transfer of a slowly changing word into the core clock domain.
module vcap_handoff #(
  parameter int W      = 26,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  input  logic         tog_i,
  output logic [W-1:0] data_o,
  output logic         valid_o
);

  logic [STAGES-1:0] sy_q;
  logic              prev_q;
  logic              edge_s;

  assign edge_s = sy_q[STAGES-1] ^ prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sy_q    <= '0;
      prev_q  <= 1'b0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      sy_q    <= {sy_q[STAGES-2:0], tog_i};
      prev_q  <= sy_q[STAGES-1];
      valid_o <= edge_s;
      if (edge_s) data_o <= data_i;
    end
  end

endmodule

// File: rtl/vcap_clk_mon.sv
`timescale 1ns/1ps
// Counts pixel-clock rising edges per window of core cycles.
module vcap_clk_mon #(
  parameter int unsigned REF_KHZ     = 400000,
  parameter int unsigned WIN_CYC     = 4000,
  parameter int unsigned MIN_KHZ     = 25000,
  parameter int unsigned MAX_SDR_KHZ = 148500,
  parameter int unsigned MAX_DDR_KHZ = 74250,
  parameter int          STAGES      = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pclk_i,
  input  logic ddr_i,
  output logic low_o,
  output logic high_o
);

  localparam int          WIN_W = $clog2(WIN_CYC);
  localparam int          CNT_W = $clog2(WIN_CYC + 1);
  localparam int unsigned MIN_CNT =
    32'((64'(MIN_KHZ) * 64'(WIN_CYC)) / 64'(REF_KHZ));
  localparam int unsigned MAX_SDR_CNT =
    32'((64'(MAX_SDR_KHZ) * 64'(WIN_CYC)) / 64'(REF_KHZ));
  localparam int unsigned MAX_DDR_CNT =
    32'((64'(MAX_DDR_KHZ) * 64'(WIN_CYC)) / 64'(REF_KHZ));

  logic [STAGES-1:0] sy_q;
  logic              prev_q;
  logic              rise_s;
  logic [WIN_W-1:0]  win_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [31:0]       tot_s;
  logic [31:0]       lim_s;
  logic              last_s;

  assign rise_s = sy_q[STAGES-1] & ~prev_q;
  assign tot_s  = 32'(cnt_q) + 32'(rise_s);
  assign lim_s  = ddr_i ? MAX_DDR_CNT : MAX_SDR_CNT;
  assign last_s = (win_q == WIN_W'(WIN_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sy_q   <= '0;
      prev_q <= 1'b0;
      win_q  <= '0;
      cnt_q  <= '0;
      low_o  <= 1'b0;
      high_o <= 1'b0;
    end else begin
      sy_q   <= {sy_q[STAGES-2:0], pclk_i};
      prev_q <= sy_q[STAGES-1];
      if (last_s) begin
        win_q  <= '0;
        cnt_q  <= '0;
        low_o  <= (tot_s < MIN_CNT);
        high_o <= (tot_s > lim_s);
      end else begin
        win_q <= win_q + WIN_W'(1);
        if (rise_s) cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/vcap_top.sv
`timescale 1ns/1ps
module vcap_top #(
  parameter int          PIX_W       = 24,
  parameter int unsigned REF_KHZ     = 400000,
  parameter int unsigned WIN_CYC     = 4000,
  parameter int unsigned MIN_KHZ     = 25000,
  parameter int unsigned MAX_SDR_KHZ = 148500,
  parameter int unsigned MAX_DDR_KHZ = 74250,
  parameter int          SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [7:0]       cfg_wdata_i,
  output logic [7:0]       cfg_rdata_o,
  input  logic             pclk_i,
  input  logic [PIX_W-1:0] pix_d_i,
  input  logic             hsync_i,
  input  logic             vsync_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             pix_valid_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             clk_low_o,
  output logic             clk_high_o
);

  localparam int XW = PIX_W + 2;

  logic             ddr_s;
  logic [PIX_W-1:0] word_s;
  logic [1:0]       sync_s;
  logic             tog_s;
  logic [XW-1:0]    xfer_s;

  vcap_mode_reg u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .ddr_o   (ddr_s)
  );

  vcap_capture #(.PIX_W(PIX_W)) u_cap (
    .pclk_i  (pclk_i),
    .rst_ni  (rst_ni),
    .ddr_i   (ddr_s),
    .pix_d_i (pix_d_i),
    .hsync_i (hsync_i),
    .vsync_i (vsync_i),
    .word_o  (word_s),
    .sync_o  (sync_s),
    .tog_o   (tog_s)
  );

  vcap_handoff #(.W(XW), .STAGES(SYNC_STAGES)) u_xfer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .data_i  ({sync_s, word_s}),
    .tog_i   (tog_s),
    .data_o  (xfer_s),
    .valid_o (pix_valid_o)
  );

  assign {hsync_o, vsync_o, pix_o} = xfer_s;

  vcap_clk_mon #(
    .REF_KHZ     (REF_KHZ),
    .WIN_CYC     (WIN_CYC),
    .MIN_KHZ     (MIN_KHZ),
    .MAX_SDR_KHZ (MAX_SDR_KHZ),
    .MAX_DDR_KHZ (MAX_DDR_KHZ),
    .STAGES      (SYNC_STAGES)
  ) u_mon (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pclk_i (pclk_i),
    .ddr_i  (ddr_s),
    .low_o  (clk_low_o),
    .high_o (clk_high_o)
  );

endmodule

// File: rtl/vcap_chk.sv
`timescale 1ns/1ps
module vcap_chk
  import vcap_pkg::*;
#(
  parameter int          PIX_W   = 24,
  parameter int unsigned WIN_CYC = 4000
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [7:0]       cfg_wdata_i,
  input logic [7:0]       cfg_rdata_o,
  input logic [PIX_W-1:0] pix_o,
  input logic             pix_valid_o,
  input logic             hsync_o,
  input logic             vsync_o,
  input logic             clk_low_o,
  input logic             clk_high_o
);

  localparam int WW = $clog2(WIN_CYC);

  logic [WW-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            win_q <= '0;
    else if (win_q == WW'(WIN_CYC - 1))     win_q <= '0;
    else                                    win_q <= win_q + WW'(1);
  end

  p_rd_follows_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (cfg_rdata_o == ($past(cfg_wdata_i) & MODE_MASK)));

  p_rd_holds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(cfg_rdata_o));

  p_valid_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |=> !pix_valid_o);

  p_pix_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_o |-> $stable({hsync_o, vsync_o, pix_o}));

  p_flag_window_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q != '0) |-> $stable({clk_low_o, clk_high_o}));

endmodule

bind vcap_top vcap_chk #(.PIX_W(PIX_W), .WIN_CYC(WIN_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_rdata_o (cfg_rdata_o),
  .pix_o       (pix_o),
  .pix_valid_o (pix_valid_o),
  .hsync_o     (hsync_o),
  .vsync_o     (vsync_o),
  .clk_low_o   (clk_low_o),
  .clk_high_o  (clk_high_o)
);

// File: tb/sim_vcap_top.sv
`timescale 1ns/1ps
module sim_vcap_top;

  localparam int WIN = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        pclk = 1'b0;
  logic [23:0] pix_d = '0;
  logic        hsync = 1'b0, vsync = 1'b0;
  logic [23:0] pix;
  logic        pix_valid, hs_o, vs_o, c_low, c_high;

  always #10 clk = ~clk;

  vcap_top #(
    .PIX_W(24), .REF_KHZ(50000), .WIN_CYC(WIN), .MIN_KHZ(2000),
    .MAX_SDR_KHZ(8000), .MAX_DDR_KHZ(4000), .SYNC_STAGES(2)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .pclk_i(pclk), .pix_d_i(pix_d), .hsync_i(hsync),
    .vsync_i(vsync), .pix_o(pix), .pix_valid_o(pix_valid), .hsync_o(hs_o),
    .vsync_o(vs_o), .clk_low_o(c_low), .clk_high_o(c_high)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // expected pixel queue: {hsync, vsync, pixel}
  logic [25:0] exp_q [0:511];
  int    wr_i = 0, rd_i = 0;
  bit    mon_on = 0;
  string mon_req = "";

  always @(negedge clk) begin
    if (mon_on && pix_valid) begin
      if (rd_i < wr_i) begin
        check({hs_o, vs_o, pix} == exp_q[rd_i], mon_req, "pixel",
              32'({hs_o, vs_o, pix}), 32'(exp_q[rd_i]));
        rd_i++;
      end else begin
        check(1'b0, "R7", "extra valid", 32'(rd_i), 32'(wr_i));
      end
    end
  end

  // flag-change timing against window boundaries
  int cyc = 0;
  logic [1:0] fl_prev = 2'b00;
  always @(posedge clk) if (rst_n) cyc = cyc + 1;
  always @(negedge clk) begin
    if (rst_n) begin
      if ({c_low, c_high} != fl_prev)
        check((cyc % WIN) == 0, "R10", "flag change cycle mod window",
              32'(cyc % WIN), 32'd0);
      fl_prev = {c_low, c_high};
    end
  end

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // one pixel: a is present at the rising edge, b at the falling edge
  task automatic px(input logic [23:0] a, input logic [23:0] b,
                    input logic hs, input logic vs, input logic [25:0] exp);
    exp_q[wr_i] = exp; wr_i++;
    pix_d = a; hsync = hs; vsync = vs; #25;
    pclk = 1'b1; #25;
    pix_d = b; hsync = ~hs; vsync = ~vs; #25;
    pclk = 1'b0; #25;
  endtask

  task automatic start_burst(input string req);
    wr_i = 0; rd_i = 0; mon_req = req; mon_on = 1;
  endtask

  task automatic end_burst(input string req);
    repeat (12) @(negedge clk);
    check(rd_i == wr_i, req, "valid pulses per pclk cycle", 32'(rd_i), 32'(wr_i));
    mon_on = 0;
  endtask

  task automatic run_pclk(input int half, input int n);
    repeat (n) begin #half pclk = 1'b1; #half pclk = 1'b0; end
  endtask

  task automatic flags(input string req, input bit lo, input bit hi);
    check(c_low == lo, req, "clk_low", 32'(c_low), 32'(lo));
    check(c_high == hi, req, "clk_high", 32'(c_high), 32'(hi));
  endtask

  initial begin
    #3000000;
    check(1'b0, "watchdog", "timeout", 32'd1, 32'd0);
    finish_up();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(pix == 24'h0, "R1", "pix", 32'(pix), 32'd0);
    check(pix_valid == 1'b0, "R1", "valid", 32'(pix_valid), 32'd0);
    check({hs_o, vs_o} == 2'b00, "R1", "sync", 32'({hs_o, vs_o}), 32'd0);
    check({c_low, c_high} == 2'b00, "R1", "flags", 32'({c_low, c_high}), 32'd0);
    check(cfg_rdata == 8'h00, "R1", "mode", 32'(cfg_rdata), 32'd0);

    // R2 mode register
    begin
      logic [7:0] vals [4] = '{8'hFF, 8'h00, 8'h23, 8'hC8};
      foreach (vals[i]) begin
        write_cfg(vals[i]);
        @(negedge clk);
        check(cfg_rdata == (vals[i] & 8'hDC), "R2", "readback",
              32'(cfg_rdata), 32'(vals[i] & 8'hDC));
      end
    end

    // R3 R6 full-width sweep, falling-edge value differs
    write_cfg(8'h00);
    start_burst("R3 R6");
    for (int k = 0; k < 64; k++) begin
      logic [23:0] a;
      a = (k == 63) ? 24'hFFFFFF : 24'(k * 24'h02A5B3);
      px(a, ~a, k[0], k[1], {k[0], k[1], a});
    end
    end_burst("R7");

    // R11 option fields set, full width
    write_cfg(8'hD8);
    start_burst("R11");
    for (int k = 0; k < 16; k++) begin
      logic [23:0] a;
      a = 24'(k * 24'h11F3C7 + 5);
      px(a, a ^ 24'h5A5A5A, k[1], k[0], {k[1], k[0], a});
    end
    end_burst("R7");

    // R4 R5 R6 half-width sweep
    write_cfg(8'h04);
    start_burst("R4 R5 R6");
    for (int k = 0; k < 128; k++) begin
      logic [11:0] lo, hi;
      lo = (k == 0) ? 12'h000 : (k == 1) ? 12'hFFF : 12'(k * 877 + 3);
      hi = (k == 0) ? 12'hFFF : (k == 1) ? 12'h000 : 12'(k * 1453 + 11);
      px({12'(k * 91 + 7), lo}, {12'(k * 53 + 2000), hi}, k[2], k[0],
         {k[2], k[0], hi, lo});
    end
    end_burst("R7");

    // R11 option fields set, half width
    write_cfg(8'hFC);
    start_burst("R11");
    for (int k = 0; k < 16; k++) begin
      logic [11:0] lo, hi;
      lo = 12'(k * 301 + 9);
      hi = 12'(k * 1777 + 1);
      px({12'hABC, lo}, {12'h123, hi}, k[0], k[3], {k[0], k[3], hi, lo});
    end
    end_burst("R7");

    // R8 R9 clock monitor: min 40, max 160 full / 80 half per window
    write_cfg(8'h00);
    run_pclk(500, 60);   flags("R8", 1'b1, 1'b0);   // 20 edges
    run_pclk(100, 300);  flags("R9", 1'b0, 1'b0);   // 100 edges, full width
    run_pclk(50, 600);   flags("R9", 1'b0, 1'b1);   // 200 edges
    write_cfg(8'h04);
    run_pclk(100, 300);  flags("R9", 1'b0, 1'b1);   // 100 edges, half width
    run_pclk(200, 150);  flags("R8 R9", 1'b0, 1'b0); // 50 edges
    run_pclk(500, 60);   flags("R8", 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    finish_up();
  end

endmodule